// File: doc/BRIEF.md
# Gated Period Timer

This block is a 16-bit up-counter with a period register, a selectable prescaler, and a sticky interrupt flag. Each prescaled tick advances the count. When the count equals the period value, the next tick returns the count to zero and sets the flag. The tick source is chosen in the control word. It is either the caller's instruction-rate enable (`tick_int`) or the rising edges of an external clock. The external clock is synchronized inside the block and turned into a one-cycle pulse.

A gated accumulation mode makes the count advance only while a synchronized gate input is high. In this mode, a falling edge of the gate also sets the flag, so software can read how long the gate was open. A stop-in-idle bit freezes the timer while the `idle` input is asserted.

Software uses a simple strobe bus. There are separate write strobes for the control, count and period registers. A read select drives `rdata`, and a clear strobe resets the flag. No data stream passes through the block, so every pin is a plain control or status signal.

Top module: `gated_period_timer`

## Requirements
- R1: After reset, the count, period, control word, flag and request are all zero.
- R2: Control bits 5:4 select the prescale ratio. The value 0 gives 1:1, 1 gives 1:8, 2 gives 1:64 and 3 gives 1:256. After N source ticks from a cleared prescaler, the count is floor(N / ratio).
- R3: When the count equals the period value, the next prescaled tick loads 0x0000 and sets the flag. With a period of 0x0000, every tick sets the flag and the count stays at zero.
- R4: A count write (`tmr_wr`) loads `wdata` into the count on the next edge. This load wins over an increment or reload in the same cycle. A control write leaves the count unchanged.
- R5: The prescaler counter is cleared by a count write and whenever enable (control bit 15) is 0.
- R6: Gated mode is active when control bit 6 is 1, bit 15 is 1 and bit 1 is 0. In this mode, ticks advance the count only while the gate input, delayed by a two-flop synchronizer, is high. A gate held high for M clock edges adds M counts at 1:1.
- R7: In gated mode, a falling edge of the synchronized gate sets the flag one edge after the synchronized level drops.
- R8: The flag stays set until a `flag_clr` strobe clears it. A set in the same cycle wins over the clear. `irq` is the flag ANDed with `int_en`.
- R9: When `idle` is 1 and stop-in-idle (control bit 13) is 1, the count and prescaler hold their values, and counting resumes from the held value once `idle` falls. With bit 13 at 0, counting continues during idle.
- R10: When control bit 1 is 1, each rising edge of `ext_clk` produces one source tick after synchronization. The external clock must stay at each level for at least two clock cycles.
- R11: `rsel` selects what `rdata` shows: 0 gives the control word (only bits 15, 13, 6, 5:4, 2 and 1 are stored), 1 gives the count, 2 gives the period and 3 gives zero.
- R12: While enable is 0, the count changes only through a count write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_int | input | 1 | Instruction-rate tick enable (internal source) |
| ext_clk | input | 1 | External clock, asynchronous |
| gate_in | input | 1 | Gate for accumulation mode, asynchronous |
| idle | input | 1 | Idle indication from the system |
| ctl_wr | input | 1 | Control register write strobe |
| tmr_wr | input | 1 | Count register write strobe |
| per_wr | input | 1 | Period register write strobe |
| wdata | input | 16 | Write data |
| rsel | input | 2 | Read select |
| flag_clr | input | 1 | Flag clear strobe |
| int_en | input | 1 | Interrupt enable |
| rdata | output | 16 | Read data |
| count | output | 16 | Current count |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that write strobes and `wdata` are sampled at the clock edge and are free of X once reset ends. They also assume that a halted timer is caused only by the enable and idle conditions visible in the control word. The stimulus changes every synchronous input on the falling clock edge. It holds `ext_clk` and `gate_in` steady for several clock cycles, so the synchronizers never see a level shorter than the stated minimum. Each prescale or gating test starts with a count write, so the prescaler phase is always known.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CNT_W    = 16;
  localparam int PS_W     = 8;
  localparam int B_EN     = 15;
  localparam int B_SIDL   = 13;
  localparam int B_GATE   = 6;
  localparam int B_PS_HI  = 5;
  localparam int B_PS_LO  = 4;
  localparam int B_SYNC   = 2;
  localparam int B_SRC    = 1;
  localparam logic [CNT_W-1:0] CTL_MASK = 16'hA076;

  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return PS_W'(0);
      2'd1:    return PS_W'(7);
      2'd2:    return PS_W'(63);
      default: return PS_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= 1'b0;
        else if (i == 0) sr[i] <= d;
        else sr[i] <= sr[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       tick_in,
  input  logic [1:0] sel,
  output logic       tick_out
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] lim;
  logic            wrap;

  assign lim      = ps_limit(sel);
  assign wrap     = (div_q >= lim);
  assign tick_out = run && tick_in && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (clr)            div_q <= '0;
    else if (run && tick_in) div_q <= wrap ? '0 : div_q + PS_W'(1);
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  input  logic             ext_set,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic hit;
  logic set;

  assign hit = step && (cnt == period);
  assign set = (hit && !load) || ext_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (hit)  cnt <= '0;
    else if (step) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_int,
  input  logic             ext_clk,
  input  logic             gate_in,
  input  logic             idle,
  input  logic             ctl_wr,
  input  logic             tmr_wr,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [1:0]       rsel,
  input  logic             flag_clr,
  input  logic             int_en,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             irq_flag,
  output logic             irq
);
  logic [CNT_W-1:0] ctl_q, per_q;
  logic ext_s, ext_d, gate_s, gate_d;
  logic en, sidl, gate_en, src_ext;
  logic run, gmode, src_tick, ps_tick, step, gate_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      per_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= wdata & CTL_MASK;
      if (per_wr) per_q <= wdata;
    end
  end

  assign en      = ctl_q[B_EN];
  assign sidl    = ctl_q[B_SIDL];
  assign gate_en = ctl_q[B_GATE];
  assign src_ext = ctl_q[B_SRC];

  gpt_sync #(.STAGES(2)) u_sync_ext  (.clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s));
  gpt_sync #(.STAGES(2)) u_sync_gate (.clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_d  <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      ext_d  <= ext_s;
      gate_d <= gate_s;
    end
  end

  assign run       = en && !(idle && sidl);
  assign gmode     = en && gate_en && !src_ext;
  assign src_tick  = src_ext ? (ext_s && !ext_d) : tick_int;
  assign gate_fall = gmode && gate_d && !gate_s;

  gpt_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .clr(tmr_wr || !en), .run(run),
    .tick_in(src_tick), .sel(ctl_q[B_PS_HI:B_PS_LO]), .tick_out(ps_tick)
  );

  assign step = ps_tick && (!gmode || gate_s);

  gpt_core u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .load(tmr_wr), .load_val(wdata),
    .period(per_q), .ext_set(gate_fall), .clr(flag_clr),
    .cnt(count), .flag(irq_flag)
  );

  assign irq = irq_flag && int_en;

  always_comb begin
    case (rsel)
      2'd0:    rdata = ctl_q;
      2'd1:    rdata = count;
      2'd2:    rdata = per_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tmr_wr,
  input logic [15:0] wdata,
  input logic        idle,
  input logic        en,
  input logic        sidl,
  input logic        flag_clr,
  input logic [15:0] count,
  input logic        flag
);
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> count == $past(wdata)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && idle && sidl) |=> $stable(count)); // R9
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && !en) |=> $stable(count)); // R12
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> (count == $past(count) || count == $past(count) + 16'd1 || count == 16'd0)); // R3
endmodule

bind gated_period_timer gpt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .wdata(wdata), .idle(idle),
  .en(ctl_q[15]), .sidl(ctl_q[13]), .flag_clr(flag_clr),
  .count(count), .flag(irq_flag)
);

// File: tb/gated_period_timer_test.sv
module gated_period_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_int = 0, ext_clk = 0, gate_in = 0, idle = 0;
  logic ctl_wr = 0, tmr_wr = 0, per_wr = 0, flag_clr = 0, int_en = 0;
  logic [15:0] wdata = '0;
  logic [1:0]  rsel = 2'd1;
  logic [15:0] rdata, count;
  logic irq_flag, irq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  gated_period_timer uut (.*);

  // {prescale select, source ticks, expected count}
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 12'd5,   12'd5},
    {2'd1, 12'd20,  12'd2},
    {2'd1, 12'd7,   12'd0},
    {2'd2, 12'd130, 12'd2},
    {2'd3, 12'd600, 12'd2},
    {2'd0, 12'd0,   12'd0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int which, logic [15:0] v);
    @(negedge clk);
    wdata = v;
    ctl_wr = (which == 0); tmr_wr = (which == 1); per_wr = (which == 2);
    @(negedge clk);
    ctl_wr = 0; tmr_wr = 0; per_wr = 0;
  endtask

  task automatic ticks(int n);
    tick_int = 1;
    repeat (n) @(negedge clk);
    tick_int = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rsel = 2'd0; #0 check("R1 ctl", rdata, 16'h0000);
    rsel = 2'd2; #0 check("R1 period", rdata, 16'h0000);
    check("R1 count", count, 16'h0000);
    check("R1 flag", {15'd0, irq_flag}, 16'h0000);
    rst_n = 1'b1;
    rsel = 2'd1;

    wr(2, 16'hFFFF);
    // R2 vector loop over prescale ratios
    foreach (VEC[i]) begin
      wr(0, 16'h8000 | (16'(VEC[i][25:24]) << 4));
      wr(1, 16'h0000);
      ticks(int'(VEC[i][23:12]));
      check("R2 prescale", count, 16'(VEC[i][11:0]));
    end

    // R11 readback
    wr(0, 16'hFFFF);
    rsel = 2'd0; #1 check("R11 ctl", rdata, 16'hA076);
    rsel = 2'd2; #1 check("R11 period", rdata, 16'hFFFF);
    rsel = 2'd3; #1 check("R11 zero", rdata, 16'h0000);
    rsel = 2'd1;

    // R3 period match
    wr(0, 16'h8000); wr(2, 16'd3); wr(1, 16'd0);
    ticks(3);
    check("R3 before", count, 16'd3);
    check("R3 noflag", {15'd0, irq_flag}, 16'd0);
    ticks(1);
    check("R3 reload", count, 16'd0);
    check("R3 flag", {15'd0, irq_flag}, 16'd1);

    // R8 sticky flag and request gating
    repeat (5) @(negedge clk);
    check("R8 sticky", {15'd0, irq_flag}, 16'd1);
    check("R8 irq off", {15'd0, irq}, 16'd0);
    int_en = 1; #1 check("R8 irq on", {15'd0, irq}, 16'd1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R8 clear", {15'd0, irq_flag}, 16'd0);

    // R3 period zero with R8 set-over-clear
    wr(2, 16'd0); wr(1, 16'd0);
    tick_int = 1; flag_clr = 1; @(negedge clk); tick_int = 0; flag_clr = 0;
    check("R3 zero count", count, 16'd0);
    check("R8 set wins", {15'd0, irq_flag}, 16'd1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R4 write priority and control write
    wr(2, 16'hFFFF);
    wdata = 16'h1234; tmr_wr = 1; tick_int = 1; @(negedge clk); tmr_wr = 0; tick_int = 0;
    check("R4 priority", count, 16'h1234);
    wr(0, 16'h8010);
    check("R4 ctl keeps", count, 16'h1234);

    // R5 prescaler clear on count write and on disable
    wr(1, 16'd0); ticks(5); wr(1, 16'd0); ticks(5);
    check("R5 write clr", count, 16'd0);
    ticks(3);
    check("R5 after", count, 16'd1);
    wr(1, 16'd0); ticks(5); wr(0, 16'h0010); wr(0, 16'h8010); ticks(3);
    check("R5 en clr", count, 16'd0);

    // R12 disabled holds
    wr(0, 16'h0000); ticks(6);
    check("R12 hold", count, 16'd0);

    // R9 idle
    wr(0, 16'hA000); wr(1, 16'd0);
    idle = 1; ticks(5);
    check("R9 stopped", count, 16'd0);
    idle = 0; ticks(3);
    check("R9 resume", count, 16'd3);
    wr(0, 16'h8000); idle = 1; ticks(4); idle = 0;
    check("R9 run in idle", count, 16'd7);

    // R6 / R7 gated accumulation
    wr(0, 16'h8040); wr(1, 16'd0);
    tick_int = 1;
    repeat (6) @(negedge clk);
    check("R6 gate low", count, 16'd0);
    gate_in = 1;
    repeat (10) @(negedge clk);
    gate_in = 0;
    repeat (2) @(negedge clk);
    check("R6 accumulate", count, 16'd10);
    check("R7 not yet", {15'd0, irq_flag}, 16'd0);
    @(negedge clk);
    check("R7 fall flag", {15'd0, irq_flag}, 16'd1);
    tick_int = 0;
    flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R10 external clock
    wr(0, 16'h8002); wr(1, 16'd0);
    for (int k = 0; k < 4; k++) begin
      ext_clk = 1; repeat (3) @(negedge clk);
      ext_clk = 0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R10 ext edges", count, 16'd4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule